// File: doc/BRIEF.md
# Writeback Port Reservation Scheduler

This block sits in the issue stage of a pipeline. The functional units in that pipeline have different fixed latencies, and all of them share one register-file write port. Decode offers at most one candidate instruction per cycle. Each candidate carries three things: a valid bit, a flag saying whether it writes a register, and the latency of its unit.

The scheduler keeps a small shift register that records which upcoming cycles already own the write port. A candidate that writes a register is allowed to issue only if the cycle in which it would write back is still free. When it issues, that cycle is booked. When the cycle is already taken, the scheduler raises a stall toward decode. Decode then holds that instruction and everything behind it, and stops fetching. Instructions already issued keep moving.

Write-port conflicts are therefore settled once, at issue. No arbitration happens at writeback time. A synchronous flush drops every booking.

Top module: `wbr_sched`

## Requirements
- R1: After reset no cycle is booked. `wb_busy_o` is low, and with no candidate present both `issue_o` and `stall_o` are low.
- R2: A valid candidate with `cand_wr_i` low issues in the same cycle whatever the bookings are, and it books nothing.
- R3: A valid writing candidate with latency L (1..7) issues in the same cycle if the cycle L clocks ahead is free. `wb_busy_o` is then high exactly L rising edges after that issue cycle.
- R4: A valid writing candidate whose writeback cycle is already booked gets `stall_o` high and `issue_o` low, and adds no booking.
- R5: Bookings move one cycle closer every clock. `wb_busy_o` reports whether the current cycle is booked.
- R6: A latency field of 0 is handled exactly as a latency of 1.
- R7: While `flush_i` is high the candidate neither issues nor stalls, and after that edge no cycle is booked.
- R8: `issue_o` and `stall_o` are never high together, and both are low when `cand_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Synchronous clear of all bookings |
| cand_valid_i | input | 1 | Candidate instruction present |
| cand_wr_i | input | 1 | Candidate writes a register |
| cand_lat_i | input | LAT_W | Unit latency in cycles (0 means 1) |
| issue_o | output | 1 | Candidate issues this cycle |
| stall_o | output | 1 | Hold decode this cycle |
| wb_busy_o | output | 1 | Write port booked in the current cycle |

## Verification
The bench drives the block with directed conflicts and with long pseudo-random streams. It compares every output on every clock against a model that books absolute cycle numbers.

Several corner cases get targeted stimulus:
- A later short-latency instruction that lands on the same cycle as an earlier long one. A design that gets this wrong issues both and double-drives the port.
- A latency-0 field. An off-by-one here books cycle zero or the wrong slot, and shows up as a busy flag one cycle early or late.
- A stalled writer. If it books anyway, later instructions see phantom conflicts.
- A flush placed between booking and writeback. If it fails to clear, a stale busy flag appears after the flush.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  // Latency field of zero is promoted to one cycle.
  function automatic int unsigned eff_lat(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // Position in the post-shift vector at which a granted writer books.
  function automatic int unsigned land_pos(input int unsigned raw);
    return eff_lat(raw) - 1;
  endfunction
endpackage

// File: rtl/wbr_grant.sv
module wbr_grant #(
  parameter int LAT_W = 3,
  localparam int DEPTH = 1 << LAT_W
) (
  input  logic             flush_i,
  input  logic             valid_i,
  input  logic             wr_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic [DEPTH-1:0] res_q,
  output logic             grant_o,
  output logic             stall_o,
  output logic             clash_o,
  output logic [DEPTH-1:0] set_mask_o
);
  import wbr_pkg::*;

  logic [LAT_W-1:0] lat_eff;

  always_comb begin
    lat_eff    = LAT_W'(eff_lat(int'(lat_i)));
    clash_o    = wr_i && res_q[lat_eff];
    grant_o    = valid_i && !flush_i && !clash_o;
    stall_o    = valid_i && !flush_i && clash_o;
    set_mask_o = '0;
    if (grant_o && wr_i)
      set_mask_o[land_pos(int'(lat_i))] = 1'b1;
  end
endmodule

// File: rtl/wbr_resv.sv
module wbr_resv #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [DEPTH-1:0] set_mask_i,
  output logic [DEPTH-1:0] res_q
);
  logic [DEPTH-1:0] aged;

  assign aged = res_q >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_q <= '0;
    else if (flush_i) res_q <= '0;
    else              res_q <= aged | set_mask_i;
  end

  // R7
  flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (res_q == '0));

  // R5
  age_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && set_mask_i == '0) |=> (res_q == ($past(res_q) >> 1)));
endmodule

// File: rtl/wbr_sched.sv
module wbr_sched #(
  parameter int LAT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             cand_valid_i,
  input  logic             cand_wr_i,
  input  logic [LAT_W-1:0] cand_lat_i,
  output logic             issue_o,
  output logic             stall_o,
  output logic             wb_busy_o
);
  import wbr_pkg::*;
  localparam int DEPTH = 1 << LAT_W;

  logic [DEPTH-1:0] res_q;
  logic [DEPTH-1:0] set_mask;
  logic             clash;
  logic [LAT_W-1:0] lat_eff;

  assign lat_eff = LAT_W'(eff_lat(int'(cand_lat_i)));

  wbr_grant #(.LAT_W(LAT_W)) u_grant (
    .flush_i   (flush_i),
    .valid_i   (cand_valid_i),
    .wr_i      (cand_wr_i),
    .lat_i     (cand_lat_i),
    .res_q     (res_q),
    .grant_o   (issue_o),
    .stall_o   (stall_o),
    .clash_o   (clash),
    .set_mask_o(set_mask)
  );

  wbr_resv #(.DEPTH(DEPTH)) u_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush_i   (flush_i),
    .set_mask_i(set_mask),
    .res_q     (res_q)
  );

  assign wb_busy_o = res_q[0];

  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_o && stall_o) && (cand_valid_i || (!issue_o && !stall_o)));

  // R3
  no_double_book_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && cand_wr_i) |=> res_q[$past(lat_eff) - 1]);

  // R4
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (cand_wr_i && clash && !flush_i));

  // R2
  nowr_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid_i && !cand_wr_i && !flush_i) |-> issue_o);
endmodule

// File: tb/wbr_sched_tb.sv
module wbr_sched_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 1'b0, cand_valid_i = 1'b0, cand_wr_i = 1'b0;
  logic [2:0] cand_lat_i = '0;
  logic issue_o, stall_o, wb_busy_o;

  int total = 0, bad = 0, cyc = 0;
  bit booked[int];
  bit done = 1'b0;

  always #10 clk = ~clk;

  wbr_sched #(.LAT_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .cand_valid_i(cand_valid_i),
    .cand_wr_i(cand_wr_i), .cand_lat_i(cand_lat_i),
    .issue_o(issue_o), .stall_o(stall_o), .wb_busy_o(wb_busy_o));

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  // Apply one cycle of stimulus, compare against the model, advance the model.
  task automatic step(input bit v, input bit w, input int lat, input bit fl);
    int l;
    bit exp_iss, exp_stl, exp_busy;
    string tag;
    @(negedge clk);
    cand_valid_i = v; cand_wr_i = w; cand_lat_i = 3'(lat); flush_i = fl;
    #5;
    l = (lat == 0) ? 1 : lat;
    exp_busy = booked.exists(cyc);
    exp_iss  = v && !fl && !(w && booked.exists(cyc + l));
    exp_stl  = v && !fl && w && booked.exists(cyc + l);
    if (!v) tag = "R8";
    else if (fl) tag = "R7";
    else if (lat == 0) tag = "R6";
    else if (!w) tag = "R2";
    else if (exp_iss) tag = "R3";
    else tag = "R4";
    check(tag, "issue_o", int'(issue_o), int'(exp_iss));
    check(tag, "stall_o", int'(stall_o), int'(exp_stl));
    check(fl ? "R7" : "R5", "wb_busy_o", int'(wb_busy_o), int'(exp_busy));
    if (fl) booked.delete();
    else if (exp_iss && w) booked[cyc + l] = 1'b1;
    if (booked.exists(cyc)) booked.delete(cyc);
    cyc++;
  endtask

  initial begin
    #10_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    // R1 reset state
    check("R1", "wb_busy_o", int'(wb_busy_o), 0);
    check("R1", "issue_o", int'(issue_o), 0);
    check("R1", "stall_o", int'(stall_o), 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    // R3/R4: long then short landing on the same cycle
    step(1, 1, 5, 0);
    step(1, 1, 4, 0);   // lands cycle+5 of previous -> stall
    step(1, 1, 3, 0);   // also lands there -> stall
    step(1, 0, 3, 0);   // R2 non-writer issues
    step(1, 1, 1, 0);
    step(0, 0, 0, 0);
    // R6 latency 0 vs 1
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    step(1, 1, 1, 0);
    step(1, 1, 7, 0);
    step(1, 1, 7, 0);
    step(1, 1, 6, 0);   // same landing as previous -> stall
    // R7 flush with bookings pending
    step(1, 1, 3, 1);
    step(1, 1, 6, 0);
    step(0, 0, 0, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0);
    // Random stream
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      step(r < 80, (r % 4) != 0, int'($urandom % 8), r == 99);
    end
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule